// File: doc/BRIEF.md
# Accumulator Instruction Execute Unit

This block executes one 14-bit instruction word at a time against an 8-bit accumulator. The six high bits of the word select the operation. The eight low bits are either an immediate operand or an address into a small data memory held inside the block. The unit performs add, subtract, AND, OR, invert and nibble swap. It writes the result back to the accumulator and refreshes four status flags. A one-cycle completion pulse marks the moment the new accumulator and flags are visible.

An upstream fetch stage presents a word together with a valid strobe. The data memory is loaded through a simple write port. Operations that take an immediate complete after one clock. The memory-operand add needs an extra clock for the synchronous read. A word whose opcode is not in the map changes nothing except the illegal indication.

Top module: `acc_exec_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit clears the accumulator, all flags, `done_out` and `illegal_out`.
- R2: Opcode 6'b110001 (word bits 13:8) adds the immediate in bits 7:0 to the accumulator. Carry is the unsigned carry out of bit 7. Overflow is set when both inputs have the same sign and the result sign differs. Example: word 14'b11000100010100 adds 0x14.
- R3: Opcode 6'b110010 subtracts the immediate from the accumulator. Carry is set when no borrow occurs (accumulator >= immediate, unsigned). Overflow follows the signed two's-complement rule for subtraction.
- R4: Opcodes 6'b110011 (AND immediate), 6'b110100 (OR immediate) and 6'b110101 (bitwise invert of the accumulator, operand bits ignored) clear carry and overflow.
- R5: Opcode 6'b110110 exchanges the upper and lower four bits of the accumulator and clears carry and overflow.
- R6: `flags_out` is {negative, zero, carry, overflow} on bits 3..0. Negative is bit 7 of the new accumulator; zero is set when the new accumulator is 0x00.
- R7: Opcode 6'b010001 adds the data-memory word at address operand[3:0] to the accumulator, with flags as in R2. The operand's upper four bits are ignored.
- R8: With a strobe sampled at clock edge E, `done_out` is high for exactly the cycle after E for immediate and illegal words. For the memory form it is low in that cycle and high for exactly one cycle after edge E+1. The accumulator and flags change together with `done_out`.
- R9: A strobe presented in the cycle right after a memory-form word is accepted is ignored. It causes no change and no completion pulse.
- R10: Any opcode outside R2 to R7 leaves the accumulator and flags unchanged and completes with `illegal_out` high. `illegal_out` is low after every legal completion and holds its value between completions.
- R11: A data-memory write on the same edge as a memory-form read of the same address delivers the old contents to the add. The new value is seen by later reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | Instruction word strobe |
| instr_word | input | 14 | Opcode in bits 13:8, operand in bits 7:0 |
| mem_wr_en | input | 1 | Data-memory write enable |
| mem_wr_addr | input | 4 | Data-memory write address |
| mem_wr_data | input | 8 | Data-memory write data |
| acc_out | output | 8 | Accumulator |
| flags_out | output | 4 | {negative, zero, carry, overflow} |
| illegal_out | output | 1 | Last completed word had an unknown opcode |
| done_out | output | 1 | One-cycle completion pulse |

## Verification
Two collisions are provoked. In the first, a memory write and a memory-operand read hit the same address on the same edge. The bench judges the accumulator against the pre-write contents, then reads the address again to see the new value. In the second, a new strobe arrives in the cycle the memory-form word is still waiting for its read data. The bench holds the strobe for that cycle and expects the accumulator to show only the memory add, with no second completion pulse. A behavioural model compares all outputs on every clock. It runs through both directed cases and a long stretch of mixed words and memory writes, in which such overlaps recur.

// File: rtl/acc_exec_pkg.sv
// Shared definitions for the accumulator execute unit: opcode values,
// internal ALU operation codes and the status flag layout.
// Assumes a 6-bit opcode field; the data width is set per instance.
package acc_exec_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_ADD_IMM = 6'b110001;
    localparam logic [OPC_W-1:0] OPC_SUB_IMM = 6'b110010;
    localparam logic [OPC_W-1:0] OPC_AND_IMM = 6'b110011;
    localparam logic [OPC_W-1:0] OPC_OR_IMM  = 6'b110100;
    localparam logic [OPC_W-1:0] OPC_INVERT  = 6'b110101;
    localparam logic [OPC_W-1:0] OPC_NIBSWAP = 6'b110110;
    localparam logic [OPC_W-1:0] OPC_ADD_MEM = 6'b010001;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_INV,
        ALU_SWAP,
        ALU_HOLD
    } alu_op_e;

    // bit 3 negative, bit 2 zero, bit 1 carry, bit 0 overflow
    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } status_t;

endpackage

// File: rtl/acc_opc_decode.sv
// Opcode decoder: maps the opcode field to an ALU operation and marks
// memory-operand and unknown opcodes. Purely combinational.
// Assumes the opcode values defined in acc_exec_pkg.
module acc_opc_decode
    import acc_exec_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output alu_op_e          op,
    output logic             uses_mem,
    output logic             unknown
);

    // Translate opcode to operation class and side information.
    always_comb begin
        op       = ALU_HOLD;
        uses_mem = 1'b0;
        unknown  = 1'b0;
        case (opc)
            OPC_ADD_IMM: op = ALU_ADD;
            OPC_SUB_IMM: op = ALU_SUB;
            OPC_AND_IMM: op = ALU_AND;
            OPC_OR_IMM:  op = ALU_OR;
            OPC_INVERT:  op = ALU_INV;
            OPC_NIBSWAP: op = ALU_SWAP;
            OPC_ADD_MEM: begin
                op       = ALU_ADD;
                uses_mem = 1'b1;
            end
            default:     unknown = 1'b1;
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
// Combinational arithmetic/logic stage: computes a result and the four
// status flags from the accumulator value and one operand.
// Assumes DATA_W is even so that the nibble swap splits it in halves.
module acc_alu
    import acc_exec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result,
    output status_t           status
);

    localparam int HALF = DATA_W / 2;
    localparam int MSB  = DATA_W - 1;

    logic [DATA_W:0] wide;
    logic            cy;
    logic            ov;

    // Compute result, carry and signed overflow for the selected operation.
    always_comb begin
        wide   = '0;
        result = a;
        cy     = 1'b0;
        ov     = 1'b0;
        case (op)
            ALU_ADD: begin
                wide   = {1'b0, a} + {1'b0, b};
                result = wide[MSB:0];
                cy     = wide[DATA_W];
                ov     = (a[MSB] == b[MSB]) && (result[MSB] != a[MSB]);
            end
            ALU_SUB: begin
                wide   = {1'b0, a} - {1'b0, b};
                result = wide[MSB:0];
                cy     = ~wide[DATA_W];
                ov     = (a[MSB] != b[MSB]) && (result[MSB] != a[MSB]);
            end
            ALU_AND:  result = a & b;
            ALU_OR:   result = a | b;
            ALU_INV:  result = ~a;
            ALU_SWAP: result = {a[HALF-1:0], a[MSB:HALF]};
            default:  result = a;
        endcase
    end

    // Pack the flags in the documented order.
    always_comb begin
        status.neg   = result[MSB];
        status.zero  = (result == '0);
        status.carry = cy;
        status.ovf   = ov;
    end

endmodule

// File: rtl/acc_data_ram.sv
// Small data memory with one write port and one registered read port.
// A read and a write to the same address on one edge return the old word.
// Contents are not reset; the user loads them before reading.
module acc_data_ram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] cells [DEPTH];

    // Store write data into the addressed cell.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    // Capture the addressed cell (pre-write contents) on a read request.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= cells[rd_addr];
        end
    end

endmodule

// File: rtl/acc_exec_unit.sv
// Accumulator execute unit: decodes a 14-bit word, applies the ALU to the
// accumulator and an immediate or data-memory operand, and pulses done.
// Assumes a caller that tolerates the strobe being ignored for one cycle
// after a memory-operand word is accepted.
module acc_exec_unit
    import acc_exec_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int MEM_DEPTH = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            instr_valid,
    input  logic [OPC_W+DATA_W-1:0]         instr_word,
    input  logic                            mem_wr_en,
    input  logic [$clog2(MEM_DEPTH)-1:0]    mem_wr_addr,
    input  logic [DATA_W-1:0]               mem_wr_data,
    output logic [DATA_W-1:0]               acc_out,
    output logic [3:0]                      flags_out,
    output logic                            illegal_out,
    output logic                            done_out
);

    localparam int ADDR_W = $clog2(MEM_DEPTH);
    localparam int WORD_W = OPC_W + DATA_W;

    logic [DATA_W-1:0] acc_q;
    status_t           flags_q;
    logic              ill_q;
    logic              done_q;
    logic              pend_q;

    logic [OPC_W-1:0]  opc;
    logic [DATA_W-1:0] opnd;
    alu_op_e           dec_op;
    logic              dec_mem;
    logic              dec_unknown;
    logic              accept;
    alu_op_e           alu_op;
    logic [DATA_W-1:0] alu_b;
    logic [DATA_W-1:0] alu_res;
    status_t           alu_st;
    logic [DATA_W-1:0] ram_q;

    assign opc    = instr_word[WORD_W-1:DATA_W];
    assign opnd   = instr_word[DATA_W-1:0];
    assign accept = instr_valid && !pend_q;

    acc_opc_decode u_decode (
        .opc      (opc),
        .op       (dec_op),
        .uses_mem (dec_mem),
        .unknown  (dec_unknown)
    );

    acc_data_ram #(
        .DATA_W (DATA_W),
        .DEPTH  (MEM_DEPTH),
        .ADDR_W (ADDR_W)
    ) u_ram (
        .clk     (clk),
        .wr_en   (mem_wr_en),
        .wr_addr (mem_wr_addr),
        .wr_data (mem_wr_data),
        .rd_en   (accept && dec_mem),
        .rd_addr (opnd[ADDR_W-1:0]),
        .rd_data (ram_q)
    );

    // Select the operation and operand for the cycle being completed.
    always_comb begin
        alu_op = pend_q ? ALU_ADD : dec_op;
        alu_b  = pend_q ? ram_q : opnd;
    end

    acc_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op     (alu_op),
        .a      (acc_q),
        .b      (alu_b),
        .result (alu_res),
        .status (alu_st)
    );

    // Sequence accept, optional memory wait and write-back of the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            flags_q <= '0;
            ill_q   <= 1'b0;
            done_q  <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (pend_q) begin
                acc_q   <= alu_res;
                flags_q <= alu_st;
                ill_q   <= 1'b0;
                done_q  <= 1'b1;
                pend_q  <= 1'b0;
            end else if (accept) begin
                if (dec_unknown) begin
                    ill_q  <= 1'b1;
                    done_q <= 1'b1;
                end else if (dec_mem) begin
                    pend_q <= 1'b1;
                end else begin
                    acc_q   <= alu_res;
                    flags_q <= alu_st;
                    ill_q   <= 1'b0;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    assign acc_out     = acc_q;
    assign flags_out   = flags_q;
    assign illegal_out = ill_q;
    assign done_out    = done_q;

    // Immediate and unknown words complete on the next cycle.
    assert_imm_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !dec_mem) |=> done_q);

    // Memory-form words show no completion one cycle after acceptance.
    assert_mem_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_mem) |=> (!done_q && pend_q));

    // A pending memory read always completes on the following edge.
    assert_mem_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |=> (done_q && !pend_q));

    // An unknown opcode leaves accumulator and flags untouched.
    assert_unknown_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && ill_q) |-> (acc_q == $past(acc_q) && flags_q == $past(flags_q)));

    // Negative and zero flags agree with the accumulator after completion.
    assert_nz_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !ill_q) |-> (flags_q.zero == (acc_q == '0) && flags_q.neg == acc_q[DATA_W-1]));

endmodule

// File: tb/test_acc_exec_unit.sv
// Bench: directed cases with hand-computed values plus a behavioural
// reference model compared on every clock during mixed traffic.
module test_acc_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [13:0] instr_word;
    logic        mem_wr_en;
    logic [3:0]  mem_wr_addr;
    logic [7:0]  mem_wr_data;
    logic [7:0]  acc_out;
    logic [3:0]  flags_out;
    logic        illegal_out;
    logic        done_out;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit cmp_en = 1'b0;

    always #5 clk = ~clk;

    acc_exec_unit i_acc_exec_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data),
        .acc_out     (acc_out),
        .flags_out   (flags_out),
        .illegal_out (illegal_out),
        .done_out    (done_out)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int m_acc, m_flags, m_ill, m_done, m_pend, m_rd;
    int m_mem [16];

    function automatic int sx(input int x);
        return (x >= 128) ? x - 256 : x;
    endfunction

    function automatic void model_alu(input int opc, input int a, input int b,
                                      output int r, output int fl);
        int s;
        int c = 0;
        int v = 0;
        r = a;
        case (opc)
            6'b110001, 6'b010001: begin
                s = a + b; r = s % 256; c = (s > 255);
                s = sx(a) + sx(b); v = (s > 127 || s < -128);
            end
            6'b110010: begin
                r = (a - b + 256) % 256; c = (a >= b);
                s = sx(a) - sx(b); v = (s > 127 || s < -128);
            end
            6'b110011: r = a & b;
            6'b110100: r = a | b;
            6'b110101: r = 255 - a;
            6'b110110: r = (a % 16) * 16 + a / 16;
            default: r = a;
        endcase
        fl = ((r >= 128) ? 8 : 0) + ((r == 0) ? 4 : 0) + c * 2 + v;
    endfunction

    function automatic bit known(input int opc);
        return opc == 6'b110001 || opc == 6'b110010 || opc == 6'b110011 ||
               opc == 6'b110100 || opc == 6'b110101 || opc == 6'b110110 ||
               opc == 6'b010001;
    endfunction

    always @(posedge clk) begin
        int r, fl, opc, imm;
        if (!rst_n) begin
            m_acc <= 0; m_flags <= 0; m_ill <= 0; m_done <= 0; m_pend <= 0;
        end else begin
            if (mem_wr_en) m_mem[mem_wr_addr] <= mem_wr_data;
            m_done <= 0;
            if (m_pend != 0) begin
                model_alu(6'b010001, m_acc, m_rd, r, fl);
                m_acc <= r; m_flags <= fl; m_ill <= 0; m_done <= 1; m_pend <= 0;
            end else if (instr_valid) begin
                opc = int'(instr_word[13:8]);
                imm = int'(instr_word[7:0]);
                if (!known(opc)) begin
                    m_ill <= 1; m_done <= 1;
                end else if (opc == 6'b010001) begin
                    m_pend <= 1; m_rd <= m_mem[imm % 16];
                end else begin
                    model_alu(opc, m_acc, imm, r, fl);
                    m_acc <= r; m_flags <= fl; m_ill <= 0; m_done <= 1;
                end
            end
        end
    end

    // Compare every output against the model on each clock.
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk("R2 model acc", int'(acc_out), m_acc);
            chk("R6 model flags", int'(flags_out), m_flags);
            chk("R8 model done", int'(done_out), m_done);
            chk("R10 model illegal", int'(illegal_out), m_ill);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- directed helpers ----------------
    task automatic mem_write(input int addr, input int data);
        @(negedge clk);
        mem_wr_en = 1'b1; mem_wr_addr = 4'(addr); mem_wr_data = 8'(data);
        @(negedge clk);
        mem_wr_en = 1'b0;
    endtask

    task automatic run_imm(input logic [5:0] opc, input logic [7:0] imm,
                           input int exp_acc, input int exp_fl, input string tag);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = {opc, imm};
        @(negedge clk);
        instr_valid = 1'b0;
        chk({tag, " done after one cycle R8"}, int'(done_out), 1);
        chk({tag, " acc"}, int'(acc_out), exp_acc);
        chk({tag, " flags"}, int'(flags_out), exp_fl);
        @(negedge clk);
        chk({tag, " single pulse R8"}, int'(done_out), 0);
    endtask

    task automatic run_mem(input logic [7:0] addr, input int exp_acc, input int exp_fl,
                           input bit hold_strobe, input string tag);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = {6'b010001, addr};
        @(negedge clk);
        if (hold_strobe) instr_word = {6'b110001, 8'h01};
        else instr_valid = 1'b0;
        chk({tag, " no done yet R8"}, int'(done_out), 0);
        @(negedge clk);
        instr_valid = 1'b0;
        chk({tag, " done after two cycles R8"}, int'(done_out), 1);
        chk({tag, " acc"}, int'(acc_out), exp_acc);
        chk({tag, " flags"}, int'(flags_out), exp_fl);
        chk({tag, " illegal low R10"}, int'(illegal_out), 0);
        @(negedge clk);
        chk({tag, " single pulse R8"}, int'(done_out), 0);
        chk({tag, " acc after pulse"}, int'(acc_out), exp_acc);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0;
        mem_wr_en = 1'b0; mem_wr_addr = '0; mem_wr_data = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset acc", int'(acc_out), 0);
        chk("R1 reset flags", int'(flags_out), 0);
        chk("R1 reset done", int'(done_out), 0);
        chk("R1 reset illegal", int'(illegal_out), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) mem_write(i, (i * 37 + 11) % 256);
        mem_write(3, 8'hC1);
        mem_write(5, 8'h02);
        cmp_en = 1'b1;

        run_imm(6'b110001, 8'h14, 8'h14, 4'b0000, "R2 add 0x14");
        run_imm(6'b110001, 8'h6C, 8'h80, 4'b1001, "R2 add signed overflow");
        run_imm(6'b110010, 8'h80, 8'h00, 4'b0110, "R3 sub to zero no borrow");
        run_imm(6'b110010, 8'h01, 8'hFF, 4'b1000, "R3 sub borrow");
        run_imm(6'b110011, 8'h0F, 8'h0F, 4'b0000, "R4 and");
        run_imm(6'b110110, 8'hAA, 8'hF0, 4'b1000, "R5 nibble swap");
        run_imm(6'b110101, 8'h55, 8'h0F, 4'b0000, "R4 invert ignores operand");
        run_imm(6'b110100, 8'h30, 8'h3F, 4'b0000, "R4 or");
        run_imm(6'b000000, 8'hFF, 8'h3F, 4'b0000, "R10 unknown opcode");
        chk("R10 illegal raised", int'(illegal_out), 1);
        run_mem(8'h13, 8'h00, 4'b0110, 1'b0, "R7 mem add upper addr bits ignored");

        // R11: write and memory-form read of the same address on one edge.
        @(negedge clk);
        instr_valid = 1'b1; instr_word = {6'b010001, 8'h05};
        mem_wr_en = 1'b1; mem_wr_addr = 4'd5; mem_wr_data = 8'h77;
        @(negedge clk);
        instr_valid = 1'b0; mem_wr_en = 1'b0;
        @(negedge clk);
        chk("R11 old data used", int'(acc_out), 8'h02);
        run_mem(8'h05, 8'h79, 4'b0000, 1'b0, "R11 new data seen later");

        // R9: strobe held into the waiting cycle is ignored.
        run_mem(8'h05, 8'hF0, 4'b1001, 1'b1, "R9 strobe ignored while waiting");

        // Mixed traffic, checked by the model on every clock.
        for (int n = 0; n < 3000; n++) begin
            int sel;
            logic [5:0] opcs [8];
            opcs[0] = 6'b110001; opcs[1] = 6'b110010; opcs[2] = 6'b110011;
            opcs[3] = 6'b110100; opcs[4] = 6'b110101; opcs[5] = 6'b110110;
            opcs[6] = 6'b010001; opcs[7] = 6'($urandom);
            @(negedge clk);
            sel = int'($urandom % 8);
            instr_valid = ($urandom % 10) < 7;
            instr_word  = {opcs[sel], 8'($urandom)};
            mem_wr_en   = ($urandom % 4) == 0;
            mem_wr_addr = 4'($urandom);
            mem_wr_data = 8'($urandom);
        end
        @(negedge clk);
        instr_valid = 1'b0; mem_wr_en = 1'b0;
        repeat (4) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule